// File: doc/BRIEF.md
# Drive Status Word Builder

This block keeps one status register per attached disk drive and, when asked, turns the register of one drive into the 16-bit status word that goes back to the host. Other controller logic changes the stored bits with set and clear pulses. A drive coming online raises its attention and first-status bits. A controller-level clear returns every register to its idle state.

The returned word is not a plain copy of the register. It takes in the drive-present and write-protect inputs and the controller variant, and bit 0 is worked out as a summary of every other error bit. A status read also clears the sticky event bits of the drive that was read. The seek-related bits and the not-ready bit are left alone.

Top module: `drive_status_word`

## Requirements
- R1: For a present drive in the 12-sector variant (`variant_24`=0), every register bit except bits 7 and 0 appears unchanged at its own position in the word. Bits 15 attention, 14 first status, 13 overrun, 12 read/write unsafe, 11 access unsafe, 10 hunting, 9 seek incomplete, 8 seek error, 6 not ready, 5 end of cylinder, 4 address error, 3 flagged, 2 seeking, 1 data error. Bit 7 always reads 0, and bits 7 and 0 are never stored.
- R2: Bit 0 of the returned word is 1 exactly when any of bits 15:8 or 6:1 of that same word is 1.
- R3: A read of a drive whose `drv_present` bit is 0 returns 16'h0045: not ready (bit 6), seeking (bit 2) and bit 0.
- R4: With `variant_24`=1, bits 15, 12 and 9 read as 0 and bit 10 equals that drive's `drv_wprot` input. The stored bits are not changed by this masking.
- R5: A status read clears bits 15, 14, 13, 12, 11, 5, 4, 3 and 1 (mask 16'hF83A) of the selected drive's register. Bits 10, 9, 8, 6 and 2 are kept. This applies whether or not the drive is present.
- R6: If a set pulse or online pulse hits a bit of the drive being read in the same cycle, the read clear wins for the bits in mask 16'hF83A. A set of a kept bit, or a set on any other drive, still takes effect.
- R7: `clr_en` clears `clr_bits` in drive `clr_sel`, and `set_en` sets `set_bits` in drive `set_sel`. When both pulses name the same bit of the same drive, the set wins.
- R8: A `ctl_clear` cycle leaves a present drive with only its bit 14 kept and clears every bit of an absent drive. It overrides set, clear, online and read-clear updates in that cycle.
- R9: A `drv_online[i]` pulse sets bits 15 and 14 of drive i.
- R10: `rd_valid` is high for exactly the one cycle after an `rd_req` cycle. `rd_word` then holds the word built from the register and inputs as they were in the request cycle, and keeps that value until the next read. Asynchronous reset clears all registers and both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant_24 | input | 1 | 1 selects the 24-sector controller variant |
| drv_present | input | NUM_DRIVES | Drive attached and ready |
| drv_wprot | input | NUM_DRIVES | Drive write-protect |
| drv_online | input | NUM_DRIVES | Pulse: drive came online |
| set_en | input | 1 | Set pulse valid |
| set_sel | input | SEL_W | Drive for the set pulse |
| set_bits | input | 16 | Bits to set |
| clr_en | input | 1 | Clear pulse valid |
| clr_sel | input | SEL_W | Drive for the clear pulse |
| clr_bits | input | 16 | Bits to clear |
| ctl_clear | input | 1 | Controller clear pulse |
| rd_req | input | 1 | Status read request |
| rd_sel | input | SEL_W | Drive to read |
| rd_valid | output | 1 | Status word valid |
| rd_word | output | 16 | Status word |

## Verification
The bench aims at reads that coincide with set pulses on the same drive. A design that gave the set priority would return a stale attention or overrun bit on the next read. It also aims at reads with the variant flag flipping between reads. A design that masked the stored register, instead of only the word, would lose the incomplete-seek bit when the variant returns to 12 sectors. Absent-drive reads and controller clears on mixed present and absent drives check that the fixed not-ready word and the keep-first-status rule apply only where they should. An error bit that ignored the masked bits, or included bit 7, shows up as a summary mismatch.

// File: rtl/drive_status_word.sv
module drive_status_word #(
  parameter int NUM_DRIVES = 4,
  localparam int SEL_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  variant_24,
  input  logic [NUM_DRIVES-1:0] drv_present,
  input  logic [NUM_DRIVES-1:0] drv_wprot,
  input  logic [NUM_DRIVES-1:0] drv_online,
  input  logic                  set_en,
  input  logic [SEL_W-1:0]      set_sel,
  input  logic [15:0]           set_bits,
  input  logic                  clr_en,
  input  logic [SEL_W-1:0]      clr_sel,
  input  logic [15:0]           clr_bits,
  input  logic                  ctl_clear,
  input  logic                  rd_req,
  input  logic [SEL_W-1:0]      rd_sel,
  output logic                  rd_valid,
  output logic [15:0]           rd_word
);
  localparam logic [15:0] KEEP_MASK   = 16'hFF7E;
  localparam logic [15:0] RDCLR_MASK  = 16'hF83A;
  localparam logic [15:0] VAR_ZERO    = 16'h9600;
  localparam logic [15:0] ONLINE_BITS = 16'hC000;
  localparam logic [15:0] ABSENT_WORD = 16'h0044;

  logic [NUM_DRIVES-1:0][15:0] stat;
  logic [15:0] sel_reg, word_body, word_next;

  assign sel_reg = stat[rd_sel];

  always_comb begin
    word_body = sel_reg & KEEP_MASK;
    if (variant_24)
      word_body = (word_body & ~VAR_ZERO) | ({15'd0, drv_wprot[rd_sel]} << 10);
    if (!drv_present[rd_sel])
      word_body = ABSENT_WORD;
    word_next = {word_body[15:1], |(word_body & KEEP_MASK)};
  end

  genvar i;
  generate
    for (i = 0; i < NUM_DRIVES; i++) begin : g_drv
      logic [15:0] set_v, clr_v, rdclr_v, nxt;
      assign set_v   = ((set_en && set_sel == SEL_W'(i)) ? set_bits : 16'd0)
                     | (drv_online[i] ? ONLINE_BITS : 16'd0);
      assign clr_v   = (clr_en && clr_sel == SEL_W'(i)) ? clr_bits : 16'd0;
      assign rdclr_v = (rd_req && rd_sel == SEL_W'(i)) ? RDCLR_MASK : 16'd0;
      assign nxt     = (((stat[i] & ~clr_v) | set_v) & KEEP_MASK) & ~rdclr_v;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          stat[i] <= '0;
        else if (ctl_clear)
          stat[i] <= drv_present[i] ? (stat[i] & 16'h4000) : 16'd0;
        else
          stat[i] <= nxt;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_word  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_word <= word_next;
    end
  end
endmodule

module drive_status_word_chk #(
  parameter int NUM_DRIVES = 4,
  parameter int SEL_W = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        variant_24,
  input logic [NUM_DRIVES-1:0]       drv_present,
  input logic                        ctl_clear,
  input logic                        rd_req,
  input logic [SEL_W-1:0]            rd_sel,
  input logic                        rd_valid,
  input logic [15:0]                 rd_word,
  input logic [NUM_DRIVES-1:0][15:0] stat
);
  // R1
  unused_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_word[7] == 1'b0);

  // R2
  summary_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_word[0] == |(rd_word & 16'hFF7E));

  // R3
  absent_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !drv_present[rd_sel]) |=> rd_word == 16'h0045);

  // R4
  variant_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && variant_24) |=> (rd_word & 16'h9200) == 16'd0);

  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !ctl_clear) |=> (stat[$past(rd_sel)] & 16'hF83A) == 16'd0);

  // R10
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  // R10
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  // R10
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rd_word));
endmodule

bind drive_status_word drive_status_word_chk #(.NUM_DRIVES(NUM_DRIVES), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .variant_24(variant_24), .drv_present(drv_present),
  .ctl_clear(ctl_clear), .rd_req(rd_req), .rd_sel(rd_sel), .rd_valid(rd_valid),
  .rd_word(rd_word), .stat(stat)
);

// File: tb/drive_status_word_test.sv
module drive_status_word_test;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic variant_24 = 1'b0;
  logic [ND-1:0] drv_present = '0, drv_wprot = '0, drv_online = '0;
  logic set_en = 1'b0, clr_en = 1'b0, ctl_clear = 1'b0, rd_req = 1'b0;
  logic [1:0] set_sel = '0, clr_sel = '0, rd_sel = '0;
  logic [15:0] set_bits = '0, clr_bits = '0;
  logic rd_valid;
  logic [15:0] rd_word;

  int vectors = 0, errors = 0;
  logic [15:0] model [ND];

  always #(CLK_PERIOD/2) clk = ~clk;

  drive_status_word #(.NUM_DRIVES(ND)) uut (
    .clk(clk), .rst_n(rst_n), .variant_24(variant_24), .drv_present(drv_present),
    .drv_wprot(drv_wprot), .drv_online(drv_online), .set_en(set_en), .set_sel(set_sel),
    .set_bits(set_bits), .clr_en(clr_en), .clr_sel(clr_sel), .clr_bits(clr_bits),
    .ctl_clear(ctl_clear), .rd_req(rd_req), .rd_sel(rd_sel), .rd_valid(rd_valid),
    .rd_word(rd_word)
  );

  function automatic logic [15:0] exp_word(int d);
    logic [15:0] w;
    if (!drv_present[d]) w = 16'h0044;
    else begin
      w = model[d] & 16'hFF7E;
      if (variant_24) begin
        w[15] = 1'b0; w[12] = 1'b0; w[9] = 1'b0;
        w[10] = drv_wprot[d];
      end
    end
    w[7] = 1'b0;
    w[0] = |w[15:8] | |w[6:1];
    return w;
  endfunction

  function automatic logic [15:0] next_model(int d);
    logic [15:0] v;
    v = model[d];
    if (ctl_clear) return drv_present[d] ? (v & 16'h4000) : 16'd0;
    if (clr_en && clr_sel == d) v &= ~clr_bits;
    if (set_en && set_sel == d) v |= set_bits;
    if (drv_online[d]) v |= 16'hC000;
    v[7] = 1'b0; v[0] = 1'b0;
    if (rd_req && rd_sel == d) v &= ~16'hF83A;
    return v;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(string req);
    logic [15:0] e;
    logic [15:0] nm [ND];
    logic r;
    r = rd_req;
    e = exp_word(int'(rd_sel));
    for (int d = 0; d < ND; d++) nm[d] = next_model(d);
    @(posedge clk);
    #1;
    for (int d = 0; d < ND; d++) model[d] = nm[d];
    check({req, " valid"}, {15'd0, rd_valid}, {15'd0, r});
    if (r) check(req, rd_word, e);
    @(negedge clk);
    set_en = 0; clr_en = 0; ctl_clear = 0; rd_req = 0; drv_online = '0;
  endtask

  task automatic rd(int d, string req);
    rd_req = 1; rd_sel = 2'(d);
    cycle(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int d = 0; d < ND; d++) model[d] = '0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check("R10 reset valid", {15'd0, rd_valid}, 16'd0);
    check("R10 reset word", rd_word, 16'd0);
    rst_n = 1;
    drv_present = 4'b0111;
    // R10 reset register state
    rd(0, "R10 reset read");
    // R3 absent drive
    rd(3, "R3 absent");
    // R1 layout, R2 summary
    set_en = 1; set_sel = 1; set_bits = 16'hFFFF; cycle("R1 set");
    rd(1, "R1 all bits");
    rd(1, "R5 kept after read");
    // R9 online
    drv_online = 4'b0100; cycle("R9 online");
    rd(2, "R9 online read");
    // R4 variant
    set_en = 1; set_sel = 0; set_bits = 16'h9600; cycle("R4 set");
    variant_24 = 1; drv_wprot = 4'b0001; rd(0, "R4 variant");
    variant_24 = 0; rd(0, "R4 stored bits intact");
    // R6 read beats set
    set_en = 1; set_sel = 2; set_bits = 16'h8004; rd(2, "R6 collide");
    rd(2, "R6 after collide");
    // R7 set beats clear
    set_en = 1; clr_en = 1; set_sel = 1; clr_sel = 1; set_bits = 16'h0100; clr_bits = 16'h0104;
    cycle("R7 set vs clear");
    rd(1, "R7 result");
    // R8 controller clear
    drv_online = 4'b1111; cycle("R8 prep");
    drv_present = 4'b0101; ctl_clear = 1; set_en = 1; set_sel = 0; set_bits = 16'h2000;
    cycle("R8 clear");
    drv_present = 4'b1111;
    for (int d = 0; d < ND; d++) rd(d, "R8 after clear");
    // random
    for (int n = 0; n < 4000; n++) begin
      drv_present = 4'($urandom);
      drv_wprot   = 4'($urandom);
      variant_24  = 1'($urandom);
      drv_online  = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'd0;
      set_en   = 1'($urandom); set_sel = 2'($urandom);
      set_bits = 16'($urandom) & 16'($urandom);
      clr_en   = 1'($urandom); clr_sel = 2'($urandom);
      clr_bits = 16'($urandom);
      ctl_clear = ($urandom_range(0, 49) == 0);
      rd_req = 1'($urandom); rd_sel = 2'($urandom);
      cycle("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule